// File: doc/BRIEF.md
# Boundary-Scan Data Register for a Nine-Pin I/O Expander

This block is the 33-cell boundary-scan data register of a small I/O expander. It is placed between TDI and TDO whenever one of the boundary-scan instructions is selected. It observes three address-strap inputs, both serial-bus pins and nine general-purpose I/O pins. For each I/O it can also take over the pull-up enable and the pull-down enable. It can also take over the open-drain pull-down of the serial-data line.

An external TAP state decoder supplies three controls. The capture strobe loads a snapshot of every pin and every functional drive value. The shift strobe moves the chain one place toward TDO on each rising TCK. The update strobe copies the output cells into shadow latches. An external instruction decoder raises `extest_i`. While it is high, the shadow latches drive the pad controls. While it is low, the functional logic drives them unchanged.

Cell 0 sits next to TDO and TDI enters the top cell. I/O pin n owns three cells: 3n observes the pin, 3n+1 controls its pull-down and 3n+2 controls its pull-up. Cell 27 controls the serial-data pull-down. Cells 28 and 29 observe serial data and serial clock. Cells 30, 31 and 32 observe straps 0, 1 and 2.

Top module: `bsr_chain`

## Requirements
- R1: The chain is exactly 33 cells long. A bit shifted in at TDI appears at TDO after exactly 33 shift clocks.
- R2: On capture, for I/O pin n, cell 3n loads the pin level, cell 3n+1 loads the functional pull-down enable and cell 3n+2 loads the functional pull-up enable.
- R3: On capture, cell 27 loads the functional serial-data pull-down, cell 28 loads the serial-data pin level and cell 29 loads the serial-clock pin level.
- R4: On capture, cells 30, 31 and 32 load address straps 0, 1 and 2, in that order.
- R5: On each rising TCK with shift asserted, every cell takes the value of the cell above it and cell 32 takes TDI. TDO shows cell 0 and changes only on falling TCK.
- R6: On a rising TCK with update asserted, each output cell's shadow latch loads the cell's value. With `extest_i` high, pad pull-up n equals latch 3n+2, pad pull-down n equals latch 3n+1 and the serial-data pull-down equals latch 27.
- R7: Values held in observe-only cells (3n, 28 to 32) have no effect on any pad output after an update.
- R8: With `extest_i` low, every pad output equals its functional input, whatever the shadow latches hold. The latches keep their contents for the next time `extest_i` goes high.
- R9: While `rst_ni` is low, every shadow latch is cleared: with `extest_i` high, no pull-up, no pull-down and no serial-data drive are asserted.
- R10: Shadow latches change only on an update. Capture and shift leave the pad outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Test-logic reset, active low, asynchronous |
| tdi_i | input | 1 | Serial test data in |
| capture_dr_i | input | 1 | Capture strobe from the TAP decoder |
| shift_dr_i | input | 1 | Shift strobe from the TAP decoder |
| update_dr_i | input | 1 | Update strobe from the TAP decoder |
| extest_i | input | 1 | Pad override enable from the instruction decoder |
| gpio_pin_i | input | 9 | I/O pin levels |
| sda_pin_i | input | 1 | Serial-data pin level |
| scl_pin_i | input | 1 | Serial-clock pin level |
| strap_pin_i | input | 3 | Address strap levels, bit k is strap k |
| func_pu_i | input | 9 | Functional pull-up enables |
| func_pd_i | input | 9 | Functional pull-down enables |
| func_sda_low_i | input | 1 | Functional serial-data pull-down |
| tdo_o | output | 1 | Serial test data out |
| pad_pu_o | output | 9 | Pull-up enables to the pads |
| pad_pd_o | output | 9 | Pull-down enables to the pads |
| pad_sda_low_o | output | 1 | Serial-data pull-down to the pad |

## Verification
Some behaviours are checked by the assertions on every TCK edge. These are the cell mapping on capture, the one-place shift with TDI entering the top cell, and TDO matching cell 0 at every rising edge. The assertions also check that the shadow latches load only on update and hold otherwise, and that the latches read zero while reset is low. Other behaviours can only be seen through the bench scenarios. These are the end-to-end length of 33, observe-only bits having no effect on the pads, the return of the latched values when `extest_i` rises again, and TDO staying steady across a rising edge.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    CELL_PIN_OBS = 2'd0,
    CELL_PULL_DN = 2'd1,
    CELL_PULL_UP = 2'd2
  } io_cell_e;

  function automatic int io_cell_idx(input int pin, input io_cell_e kind);
    return 3 * pin + int'(kind);
  endfunction

  function automatic int chain_len(input int num_io, input int num_strap);
    return 3 * num_io + 3 + num_strap;
  endfunction
endpackage

// File: rtl/bsr_obs_cell.sv
module bsr_obs_cell (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic pin_i,
  input  logic si_i,
  output logic so_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        so_o <= 1'b0;
    else if (capture_i) so_o <= pin_i;
    else if (shift_i)   so_o <= si_i;
  end
endmodule

// File: rtl/bsr_ctl_cell.sv
module bsr_ctl_cell (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic func_i,
  input  logic si_i,
  output logic so_o,
  output logic upd_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        so_o <= 1'b0;
    else if (capture_i) so_o <= func_i;
    else if (shift_i)   so_o <= si_i;
  end

  // shadow latch: changes on update only
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       upd_o <= 1'b0;
    else if (update_i) upd_o <= so_o;
  end
endmodule

// File: rtl/bsr_tdo_stage.sv
module bsr_tdo_stage (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic tdo_o
);
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_o <= 1'b0;
    else         tdo_o <= d_i;
  end
endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux #(
  parameter int WIDTH = 9
) (
  input  logic             sel_test_i,
  input  logic [WIDTH-1:0] func_i,
  input  logic [WIDTH-1:0] test_i,
  output logic [WIDTH-1:0] pad_o
);
  always_comb pad_o = sel_test_i ? test_i : func_i;
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int NUM_IO    = 9,
  parameter int NUM_STRAP = 3
) (
  input  logic                 tck_i,
  input  logic                 rst_ni,
  input  logic                 tdi_i,
  input  logic                 capture_dr_i,
  input  logic                 shift_dr_i,
  input  logic                 update_dr_i,
  input  logic                 extest_i,
  input  logic [NUM_IO-1:0]    gpio_pin_i,
  input  logic                 sda_pin_i,
  input  logic                 scl_pin_i,
  input  logic [NUM_STRAP-1:0] strap_pin_i,
  input  logic [NUM_IO-1:0]    func_pu_i,
  input  logic [NUM_IO-1:0]    func_pd_i,
  input  logic                 func_sda_low_i,
  output logic                 tdo_o,
  output logic [NUM_IO-1:0]    pad_pu_o,
  output logic [NUM_IO-1:0]    pad_pd_o,
  output logic                 pad_sda_low_o
);
  import bsr_pkg::*;

  localparam int NCELL      = chain_len(NUM_IO, NUM_STRAP);
  localparam int SDA_CTL    = 3 * NUM_IO;
  localparam int SDA_OBS    = SDA_CTL + 1;
  localparam int SCL_OBS    = SDA_CTL + 2;
  localparam int STRAP_BASE = SDA_CTL + 3;

  // link[i] is the output of cell i, link[NCELL] is TDI
  logic [NCELL:0]     link;
  logic [NCELL-1:0]   chain_q;
  logic [NUM_IO-1:0]  upd_pu, upd_pd;
  logic [0:0]         upd_sda, func_sda_w, pad_sda_w;

  assign link[NCELL] = tdi_i;
  assign chain_q     = link[NCELL-1:0];

  for (genvar n = 0; n < NUM_IO; n++) begin : g_io
    localparam int I_OBS = io_cell_idx(n, CELL_PIN_OBS);
    localparam int I_PD  = io_cell_idx(n, CELL_PULL_DN);
    localparam int I_PU  = io_cell_idx(n, CELL_PULL_UP);

    bsr_obs_cell u_obs (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_dr_i),
      .shift_i(shift_dr_i), .pin_i(gpio_pin_i[n]),
      .si_i(link[I_OBS+1]), .so_o(link[I_OBS])
    );
    bsr_ctl_cell u_pd (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_dr_i),
      .shift_i(shift_dr_i), .update_i(update_dr_i), .func_i(func_pd_i[n]),
      .si_i(link[I_PD+1]), .so_o(link[I_PD]), .upd_o(upd_pd[n])
    );
    bsr_ctl_cell u_pu (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_dr_i),
      .shift_i(shift_dr_i), .update_i(update_dr_i), .func_i(func_pu_i[n]),
      .si_i(link[I_PU+1]), .so_o(link[I_PU]), .upd_o(upd_pu[n])
    );
  end

  bsr_ctl_cell u_sda_ctl (
    .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_dr_i),
    .shift_i(shift_dr_i), .update_i(update_dr_i), .func_i(func_sda_low_i),
    .si_i(link[SDA_CTL+1]), .so_o(link[SDA_CTL]), .upd_o(upd_sda[0])
  );
  bsr_obs_cell u_sda_obs (
    .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_dr_i),
    .shift_i(shift_dr_i), .pin_i(sda_pin_i),
    .si_i(link[SDA_OBS+1]), .so_o(link[SDA_OBS])
  );
  bsr_obs_cell u_scl_obs (
    .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_dr_i),
    .shift_i(shift_dr_i), .pin_i(scl_pin_i),
    .si_i(link[SCL_OBS+1]), .so_o(link[SCL_OBS])
  );

  for (genvar k = 0; k < NUM_STRAP; k++) begin : g_strap
    bsr_obs_cell u_obs (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_dr_i),
      .shift_i(shift_dr_i), .pin_i(strap_pin_i[k]),
      .si_i(link[STRAP_BASE+k+1]), .so_o(link[STRAP_BASE+k])
    );
  end

  bsr_tdo_stage u_tdo (
    .tck_i(tck_i), .rst_ni(rst_ni), .d_i(link[0]), .tdo_o(tdo_o)
  );

  bsr_pad_mux #(.WIDTH(NUM_IO)) u_mux_pu (
    .sel_test_i(extest_i), .func_i(func_pu_i), .test_i(upd_pu), .pad_o(pad_pu_o)
  );
  bsr_pad_mux #(.WIDTH(NUM_IO)) u_mux_pd (
    .sel_test_i(extest_i), .func_i(func_pd_i), .test_i(upd_pd), .pad_o(pad_pd_o)
  );

  assign func_sda_w[0] = func_sda_low_i;
  bsr_pad_mux #(.WIDTH(1)) u_mux_sda (
    .sel_test_i(extest_i), .func_i(func_sda_w), .test_i(upd_sda), .pad_o(pad_sda_w)
  );
  assign pad_sda_low_o = pad_sda_w[0];
endmodule

// File: rtl/bsr_chain_checker.sv
module bsr_chain_checker #(
  parameter int NUM_IO    = 9,
  parameter int NUM_STRAP = 3,
  parameter int NCELL     = 33
) (
  input logic                 tck_i,
  input logic                 rst_ni,
  input logic                 tdi_i,
  input logic                 capture_dr_i,
  input logic                 shift_dr_i,
  input logic                 update_dr_i,
  input logic                 extest_i,
  input logic [NUM_IO-1:0]    gpio_pin_i,
  input logic                 sda_pin_i,
  input logic                 scl_pin_i,
  input logic [NUM_STRAP-1:0] strap_pin_i,
  input logic [NUM_IO-1:0]    func_pu_i,
  input logic [NUM_IO-1:0]    func_pd_i,
  input logic                 func_sda_low_i,
  input logic                 tdo_o,
  input logic [NUM_IO-1:0]    pad_pu_o,
  input logic [NUM_IO-1:0]    pad_pd_o,
  input logic                 pad_sda_low_o,
  input logic [NCELL-1:0]     chain_q
);
  localparam int SDA_CTL = 3 * NUM_IO;

  for (genvar n = 0; n < NUM_IO; n++) begin : g_io_chk
    a_r2_capture_io: assert property (@(posedge tck_i) disable iff (!rst_ni)
      capture_dr_i |=> chain_q[3*n] == $past(gpio_pin_i[n]) &&
                       chain_q[3*n+1] == $past(func_pd_i[n]) &&
                       chain_q[3*n+2] == $past(func_pu_i[n]));
    a_r6_update_io: assert property (@(posedge tck_i) disable iff (!rst_ni)
      update_dr_i && extest_i |=> !extest_i ||
        (pad_pd_o[n] == $past(chain_q[3*n+1]) && pad_pu_o[n] == $past(chain_q[3*n+2])));
  end

  a_r3_capture_bus: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_dr_i |=> chain_q[SDA_CTL] == $past(func_sda_low_i) &&
                     chain_q[SDA_CTL+1] == $past(sda_pin_i) &&
                     chain_q[SDA_CTL+2] == $past(scl_pin_i));

  a_r4_capture_strap: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_dr_i |=> chain_q[NCELL-1 -: NUM_STRAP] == $past(strap_pin_i));

  a_r5_shift_step: assert property (@(posedge tck_i) disable iff (!rst_ni)
    shift_dr_i && !capture_dr_i |=>
      chain_q == {$past(tdi_i), $past(chain_q[NCELL-1:1])});

  a_r5_tdo_cell0: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_o == chain_q[0]);

  a_r6_update_sda: assert property (@(posedge tck_i) disable iff (!rst_ni)
    update_dr_i && extest_i |=> !extest_i || pad_sda_low_o == $past(chain_q[SDA_CTL]));

  a_r10_hold: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_dr_i && extest_i |=> !extest_i ||
      ($stable(pad_pu_o) && $stable(pad_pd_o) && $stable(pad_sda_low_o)));

  always @(posedge tck_i) begin
    if (!rst_ni && extest_i)
      a_r9_reset_clear: assert (pad_pu_o == '0 && pad_pd_o == '0 && !pad_sda_low_o);
  end
endmodule

bind bsr_chain bsr_chain_checker #(
  .NUM_IO(NUM_IO), .NUM_STRAP(NUM_STRAP), .NCELL(NCELL)
) u_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .tdi_i(tdi_i),
  .capture_dr_i(capture_dr_i), .shift_dr_i(shift_dr_i), .update_dr_i(update_dr_i),
  .extest_i(extest_i), .gpio_pin_i(gpio_pin_i), .sda_pin_i(sda_pin_i),
  .scl_pin_i(scl_pin_i), .strap_pin_i(strap_pin_i), .func_pu_i(func_pu_i),
  .func_pd_i(func_pd_i), .func_sda_low_i(func_sda_low_i), .tdo_o(tdo_o),
  .pad_pu_o(pad_pu_o), .pad_pd_o(pad_pd_o), .pad_sda_low_o(pad_sda_low_o),
  .chain_q(chain_q)
);

// File: tb/bsr_chain_tb_top.sv
module bsr_chain_tb_top;
  localparam int TCK_PERIOD = 10;
  localparam int NIO = 9;
  localparam int NC  = 33;

  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic tdi = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0, extest = 1'b0;
  logic [NIO-1:0] gpio = '0, fpu = '0, fpd = '0;
  logic sda = 1'b0, scl = 1'b0, fsda = 1'b0;
  logic [2:0] strap = '0;
  logic tdo;
  logic [NIO-1:0] pad_pu, pad_pd;
  logic pad_sda;

  int n_chk = 0, n_err = 0;
  bit tdo_moved;

  always #(TCK_PERIOD/2) tck = ~tck;

  bsr_chain dut_i (
    .tck_i(tck), .rst_ni(rst_ni), .tdi_i(tdi), .capture_dr_i(cap),
    .shift_dr_i(shf), .update_dr_i(upd), .extest_i(extest),
    .gpio_pin_i(gpio), .sda_pin_i(sda), .scl_pin_i(scl), .strap_pin_i(strap),
    .func_pu_i(fpu), .func_pd_i(fpd), .func_sda_low_i(fsda),
    .tdo_o(tdo), .pad_pu_o(pad_pu), .pad_pd_o(pad_pd), .pad_sda_low_o(pad_sda)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected capture image from the cell map
  function automatic logic [NC-1:0] exp_capture();
    logic [NC-1:0] v;
    for (int n = 0; n < NIO; n++) begin
      v[3*n]   = gpio[n];
      v[3*n+1] = fpd[n];
      v[3*n+2] = fpu[n];
    end
    v[27] = fsda; v[28] = sda; v[29] = scl;
    v[32:30] = strap;
    return v;
  endfunction

  function automatic logic [2*NIO:0] pads_of(input logic [NC-1:0] v);
    logic [NIO-1:0] pu, pd;
    for (int n = 0; n < NIO; n++) begin
      pu[n] = v[3*n+2];
      pd[n] = v[3*n+1];
    end
    return {pu, pd, v[27]};
  endfunction

  // all tasks start and end 1 time unit after a falling edge
  task automatic clk_step();
    @(posedge tck); #1;
    @(negedge tck); #1;
  endtask

  task automatic do_capture();
    cap = 1'b1; clk_step(); cap = 1'b0;
  endtask

  task automatic do_update();
    upd = 1'b1; clk_step(); upd = 1'b0;
  endtask

  task automatic do_shift(input logic [NC-1:0] din, output logic [NC-1:0] dout);
    logic pre;
    for (int i = 0; i < NC; i++) begin
      dout[i] = tdo;
      pre = tdo;
      tdi = din[i];
      shf = 1'b1;
      @(posedge tck); #1;
      if (tdo !== pre) tdo_moved = 1'b1;
      @(negedge tck); #1;
    end
    shf = 1'b0;
    tdi = 1'b0;
  endtask

  initial begin
    #(TCK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [NC-1:0] got, vec, obs_mask;
    obs_mask = '0;
    for (int n = 0; n < NIO; n++) obs_mask[3*n] = 1'b1;
    obs_mask[32:28] = 5'h1f;

    // R9: reset state
    extest = 1'b1;
    fpu = '1; fpd = '1; fsda = 1'b1;
    @(negedge tck); #1;
    check("R9 reset pads", {pad_pu, pad_pd, pad_sda}, '0);
    check("R5 reset tdo", tdo, 1'b0);
    rst_ni = 1'b1;
    extest = 1'b0;
    @(negedge tck); #1;

    // R2 R3 R4 R5: capture sweep, walking ones then mixed patterns
    for (int p = 0; p < 24; p++) begin
      if (p < NIO) begin
        gpio = NIO'(1 << p); fpd = NIO'(~(1 << p)); fpu = NIO'(1 << ((p+3) % NIO));
      end else begin
        gpio = NIO'(p * 37); fpd = NIO'(p * 91 + 5); fpu = NIO'(p * 53 + 11);
      end
      fsda = p[0]; sda = p[1]; scl = p[2];
      strap = 3'(p * 5);
      do_capture();
      tdo_moved = 1'b0;
      do_shift('0, got);
      check("R2 io cells", got[26:0], exp_capture() & 27'h7ffffff);
      check("R3 bus cells", got[29:27], {scl, sda, fsda});
      check("R4 strap cells", got[32:30], strap);
      check("R5 tdo falling-edge only", tdo_moved, 1'b0);
    end

    // R1: length exactly 33
    vec = 33'h1_5a3c_96e1;
    do_shift(vec, got);
    do_shift('0, got);
    check("R1 chain length", got, vec);
    do_shift({1'b1, 32'h0}, got);
    do_shift('0, got);
    check("R1 last bit position", got, {1'b1, 32'h0});

    // R6 R10: load under extest
    extest = 1'b1;
    vec = 33'h0_a5c3_1e97;
    do_shift(vec, got);
    check("R10 pads held while shifting", {pad_pu, pad_pd, pad_sda}, '0);
    do_update();
    check("R6 pads from latches", {pad_pu, pad_pd, pad_sda}, pads_of(vec));
    do_capture();
    check("R10 pads held on capture", {pad_pu, pad_pd, pad_sda}, pads_of(vec));

    // R6 R7: sweep of output bits, observe bits toggled must not matter
    for (int p = 0; p < 16; p++) begin
      vec = NC'(p * 64'h1_3579_bdf1) ^ NC'(p * 64'h2468);
      do_shift(vec, got);
      do_update();
      check("R6 pad sweep", {pad_pu, pad_pd, pad_sda}, pads_of(vec));
      do_shift(vec ^ obs_mask, got);
      do_update();
      check("R7 observe bits ignored", {pad_pu, pad_pd, pad_sda}, pads_of(vec));
    end

    // R8: functional passthrough, latches retained
    extest = 1'b0;
    for (int p = 0; p < 8; p++) begin
      fpu = NIO'(p * 71); fpd = NIO'(p * 29 + 3); fsda = p[0];
      #1;
      check("R8 functional pads", {pad_pu, pad_pd, pad_sda}, {fpu, fpd, fsda});
    end
    extest = 1'b1; #1;
    check("R8 latches retained", {pad_pu, pad_pd, pad_sda}, pads_of(vec ^ obs_mask));

    // R9: reset in the middle clears latches
    rst_ni = 1'b0; #1;
    check("R9 reset clears latches", {pad_pu, pad_pd, pad_sda}, '0);
    @(negedge tck); #1;
    rst_ni = 1'b1;
    @(negedge tck); #1;
    check("R9 stays clear after reset", {pad_pu, pad_pd, pad_sda}, '0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule